// File: doc/BRIEF.md
# Double-Buffered Eight-Channel Pulse-Width Modulator

This block generates eight pulse-width modulated outputs from one system clock. Every channel owns an 8-bit period and an 8-bit duty value, an enable, an output polarity and a choice between edge-aligned and center-aligned counting. Neighbouring channels (0/1, 2/3, 4/5, 6/7) can be fused into one 16-bit channel for finer resolution. Period and duty values written by software land in shadow registers. A running channel copies them into its working registers only when its current period ends. This means a waveform never shows a half-updated cycle.

Each channel counts on one of four tick sources. Two base sources divide the system clock by a power of two. Two scaled sources further divide each base source by a programmable factor. An emergency shutdown input, once armed, latches a fault and forces all eight pins to a programmable safe level until software releases the latch.

Software programs the block through a simple write port: an address, a data byte and a write strobe. Pins are registered, so they change one clock after the counter state that causes the change.

Top module: `pwm_oct`

## Requirements
- R1: After reset, all channels are disabled, polarity bits (address 1) are all 1, all pins are 0, the shutdown flag is 0, prescalers and clock selects are 0, and the shutdown logic is disarmed.
- R2: In edge-aligned mode (bit c of address 2 is 0), an enabled channel repeats a period of P ticks. With polarity 1, it is high for min(D,P) ticks of each period, where P is written at address 16+c and D at address 24+c.
- R3: In center-aligned mode (bit c of address 2 is 1), the counter runs up from 0 to P-1 and then back down to 0. The period is 2P ticks, and with polarity 1 the output is high for 2·min(D,P) ticks.
- R4: Polarity bit c at address 1 equal to 0 inverts pin c, so it is low while the counter is below duty.
- R5: A disabled channel (bit c of address 0 is 0) drives the inverse of its polarity bit. While disabled, it copies shadow period and duty straight into its working registers, so the first period after enabling already uses them.
- R6: A period or duty write to a running channel does not change the current period; it takes effect from the next period.
- R7: Channels 0, 1, 4 and 5 use source A; channels 2, 3, 6 and 7 use source B. Base source A ticks once every 2^n clocks, with n in bits [2:0] of address 5. Base source B does the same with n in bits [6:4] of address 5.
- R8: Bit c of address 4 set selects the scaled source for channel c. The scaled source ticks once every S base ticks, where S is the byte at address 6 (for A) or 7 (for B), and S = 0 means 256.
- R9: Setting bit k of address 3 fuses channels 2k and 2k+1 into one 16-bit channel. The even channel's period and duty registers hold the high byte. The odd channel's enable, polarity, mode and clock select apply, and the even pin is held at 0.
- R10: Address 8 holds the shutdown controls: bit 0 arms, bit 1 is the input level that counts as a fault, and bit 2 is the forced pin level. When armed and the input equals the fault level, the latch sets on the next edge, and all pins take the forced level from that same edge. When disarmed, the input is ignored.
- R11: Writing address 8 with bit 3 set clears the latch unless a fault is present in the same cycle. The pins then return to normal channel behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register address |
| wr_data | input | 8 | Register write data |
| sd_in | input | 1 | Emergency shutdown input |
| pwm_o | output | 8 | PWM output pins |
| sd_flag_o | output | 1 | Shutdown latch state |

## Verification
The bench targets the shadow-to-working handoff in two ways. First, it raises the duty of a running channel during the low phase of a period. A block without buffering would drive the pin high again before the period wraps, so the bench checks that the pin stays low. Second, it reprograms a disabled channel and measures the very first period after enabling. A block that waited for a period end there would replay the stale values once.

In the fused 16-bit mode, the bench checks that the high byte comes from the even register. A swapped byte order would give a wholly different duty count, and a leaked even pin would show high cycles.

On shutdown, the bench checks four behaviours:
- The latch must hold after the input drops.
- The latch must ignore the input while disarmed.
- The latch must honour a low fault level.
- The latch must release on the clear write.

A prescaler chain that treats a scale of 0 as zero rather than 256 is caught by a directed window measurement.

// File: rtl/pwm_oct_pkg.sv
package pwm_oct_pkg;
    localparam int ADDR_W = 5;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] A_ENABLE = 5'd0;
    localparam logic [ADDR_W-1:0] A_POLAR  = 5'd1;
    localparam logic [ADDR_W-1:0] A_CENTER = 5'd2;
    localparam logic [ADDR_W-1:0] A_FUSE   = 5'd3;
    localparam logic [ADDR_W-1:0] A_CSEL   = 5'd4;
    localparam logic [ADDR_W-1:0] A_PRESC  = 5'd5;
    localparam logic [ADDR_W-1:0] A_SCALEA = 5'd6;
    localparam logic [ADDR_W-1:0] A_SCALEB = 5'd7;
    localparam logic [ADDR_W-1:0] A_SHUT   = 5'd8;
    localparam logic [ADDR_W-1:0] A_PERIOD = 5'd16;
    localparam logic [ADDR_W-1:0] A_DUTY   = 5'd24;
endpackage

// File: rtl/pwm_oct_clkgen.sv
module pwm_oct_clkgen #(
    parameter int PW = 7,
    parameter int SW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    pre_a_i,
    input  logic [2:0]    pre_b_i,
    input  logic [SW-1:0] scale_a_i,
    input  logic [SW-1:0] scale_b_i,
    output logic          tick_a_o,
    output logic          tick_b_o,
    output logic          tick_sa_o,
    output logic          tick_sb_o
);
    typedef struct packed {
        logic [PW-1:0] pre;
        logic [SW-1:0] sa;
        logic [SW-1:0] sb;
    } cg_t;

    cg_t s_d, s_q;
    logic [PW-1:0] mask_a, mask_b;

    always_comb begin
        mask_a    = PW'((PW+1)'(1) << pre_a_i) - PW'(1);
        mask_b    = PW'((PW+1)'(1) << pre_b_i) - PW'(1);
        tick_a_o  = (s_q.pre & mask_a) == mask_a;
        tick_b_o  = (s_q.pre & mask_b) == mask_b;
        tick_sa_o = tick_a_o && (s_q.sa >= scale_a_i - SW'(1));
        tick_sb_o = tick_b_o && (s_q.sb >= scale_b_i - SW'(1));
        s_d       = s_q;
        s_d.pre   = s_q.pre + PW'(1);
        if (tick_a_o) s_d.sa = tick_sa_o ? '0 : s_q.sa + SW'(1);
        if (tick_b_o) s_d.sb = tick_sb_o ? '0 : s_q.sb + SW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/pwm_oct_core.sv
module pwm_oct_core #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         en_i,
    input  logic         center_i,
    input  logic [W-1:0] per_i,
    input  logic [W-1:0] duty_i,
    output logic         on_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic         down;
        logic [W-1:0] per;
        logic [W-1:0] duty;
    } core_t;

    core_t s_d, s_q;
    logic  last;

    always_comb begin
        s_d  = s_q;
        last = ({1'b0, s_q.cnt} + (W+1)'(1)) >= {1'b0, s_q.per};
        if (!en_i) begin
            s_d.cnt  = '0;
            s_d.down = 1'b0;
            s_d.per  = per_i;
            s_d.duty = duty_i;
        end else if (tick_i) begin
            if (!center_i) begin
                if (last) begin
                    s_d.cnt  = '0;
                    s_d.per  = per_i;
                    s_d.duty = duty_i;
                end else begin
                    s_d.cnt = s_q.cnt + W'(1);
                end
            end else if (!s_q.down) begin
                if (last) s_d.down = 1'b1;
                else      s_d.cnt  = s_q.cnt + W'(1);
            end else if (s_q.cnt == '0) begin
                s_d.down = 1'b0;
                s_d.per  = per_i;
                s_d.duty = duty_i;
            end else begin
                s_d.cnt = s_q.cnt - W'(1);
            end
        end
        on_o = en_i && (s_q.cnt < s_q.duty);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/pwm_oct_pair.sv
module pwm_oct_pair #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fuse_i,
    input  logic [1:0]    en_i,
    input  logic [1:0]    center_i,
    input  logic [1:0]    tick_i,
    input  logic [CW-1:0] per_e_i,
    input  logic [CW-1:0] per_o_i,
    input  logic [CW-1:0] duty_e_i,
    input  logic [CW-1:0] duty_o_i,
    output logic [1:0]    on_o
);
    localparam int WW = 2 * CW;

    logic          on_e, on_w;
    logic [WW-1:0] per_w, duty_w;

    assign per_w  = fuse_i ? {per_e_i, per_o_i}   : {{CW{1'b0}}, per_o_i};
    assign duty_w = fuse_i ? {duty_e_i, duty_o_i} : {{CW{1'b0}}, duty_o_i};

    pwm_oct_core #(.W(CW)) u_even (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i[0]),
        .en_i(en_i[0] && !fuse_i), .center_i(center_i[0]),
        .per_i(per_e_i), .duty_i(duty_e_i), .on_o(on_e)
    );

    pwm_oct_core #(.W(WW)) u_odd (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i[1]),
        .en_i(en_i[1]), .center_i(center_i[1]),
        .per_i(per_w), .duty_i(duty_w), .on_o(on_w)
    );

    assign on_o = {on_w, on_e && !fuse_i};
endmodule

// File: rtl/pwm_oct.sv
module pwm_oct
    import pwm_oct_pkg::*;
#(
    parameter int NCH = 8,
    parameter int CW  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              sd_in,
    output logic [NCH-1:0]    pwm_o,
    output logic              sd_flag_o
);
    localparam int NP = NCH / 2;

    typedef struct packed {
        logic [NCH-1:0]         en;
        logic [NCH-1:0]         pol;
        logic [NCH-1:0]         center;
        logic [NP-1:0]          fuse;
        logic [NCH-1:0]         csel;
        logic [2:0]             pre_a;
        logic [2:0]             pre_b;
        logic [CW-1:0]          sc_a;
        logic [CW-1:0]          sc_b;
        logic                   sd_arm;
        logic                   sd_lvl;
        logic                   sd_force;
        logic                   sd_latch;
        logic [NCH-1:0][CW-1:0] per;
        logic [NCH-1:0][CW-1:0] duty;
        logic [NCH-1:0]         pins;
    } regs_t;

    regs_t          s_d, s_q;
    logic           t_a, t_b, t_sa, t_sb;
    logic [NCH-1:0] tick_ch, on_w, base;

    pwm_oct_clkgen #(.PW(7), .SW(CW)) u_clk (
        .clk(clk), .rst_n(rst_n),
        .pre_a_i(s_q.pre_a), .pre_b_i(s_q.pre_b),
        .scale_a_i(s_q.sc_a), .scale_b_i(s_q.sc_b),
        .tick_a_o(t_a), .tick_b_o(t_b), .tick_sa_o(t_sa), .tick_sb_o(t_sb)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_tick
        if ((c % 4) < 2) begin : g_a
            assign tick_ch[c] = s_q.csel[c] ? t_sa : t_a;
        end else begin : g_b
            assign tick_ch[c] = s_q.csel[c] ? t_sb : t_b;
        end
    end

    for (genvar k = 0; k < NP; k++) begin : g_pair
        pwm_oct_pair #(.CW(CW)) u_pair (
            .clk(clk), .rst_n(rst_n), .fuse_i(s_q.fuse[k]),
            .en_i(s_q.en[2*k +: 2]), .center_i(s_q.center[2*k +: 2]),
            .tick_i(tick_ch[2*k +: 2]),
            .per_e_i(s_q.per[2*k]), .per_o_i(s_q.per[2*k+1]),
            .duty_e_i(s_q.duty[2*k]), .duty_o_i(s_q.duty[2*k+1]),
            .on_o(on_w[2*k +: 2])
        );
    end

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            case (wr_addr)
                A_ENABLE: s_d.en     = wr_data[NCH-1:0];
                A_POLAR:  s_d.pol    = wr_data[NCH-1:0];
                A_CENTER: s_d.center = wr_data[NCH-1:0];
                A_FUSE:   s_d.fuse   = wr_data[NP-1:0];
                A_CSEL:   s_d.csel   = wr_data[NCH-1:0];
                A_PRESC: begin
                    s_d.pre_a = wr_data[2:0];
                    s_d.pre_b = wr_data[6:4];
                end
                A_SCALEA: s_d.sc_a = wr_data;
                A_SCALEB: s_d.sc_b = wr_data;
                A_SHUT: begin
                    s_d.sd_arm   = wr_data[0];
                    s_d.sd_lvl   = wr_data[1];
                    s_d.sd_force = wr_data[2];
                    if (wr_data[3]) s_d.sd_latch = 1'b0;
                end
                default: begin
                    if (wr_addr[4]) begin
                        if (wr_addr[3]) s_d.duty[wr_addr[2:0]] = wr_data;
                        else            s_d.per[wr_addr[2:0]]  = wr_data;
                    end
                end
            endcase
        end
        if (s_q.sd_arm && (sd_in == s_q.sd_lvl)) s_d.sd_latch = 1'b1;
        for (int c = 0; c < NCH; c++) begin
            base[c] = on_w[c] ? s_q.pol[c] : !s_q.pol[c];
            if ((c % 2 == 0) && s_q.fuse[c/2]) base[c] = 1'b0;
        end
        s_d.pins = s_d.sd_latch ? {NCH{s_d.sd_force}} : base;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.pol <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign pwm_o     = s_q.pins;
    assign sd_flag_o = s_q.sd_latch;

    logic [NCH-1:0] en_w, pol_w;
    logic [NP-1:0]  fuse_w;
    logic           arm_w, lvl_w, force_w;
    assign en_w    = s_q.en;
    assign pol_w   = s_q.pol;
    assign fuse_w  = s_q.fuse;
    assign arm_w   = s_q.sd_arm;
    assign lvl_w   = s_q.sd_lvl;
    assign force_w = s_q.sd_force;
endmodule

// File: rtl/pwm_oct_chk.sv
module pwm_oct_chk #(
    parameter int NCH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sd_in,
    input logic [NCH-1:0]   pwm_o,
    input logic             sd_flag_o,
    input logic [NCH-1:0]   en_w,
    input logic [NCH-1:0]   pol_w,
    input logic [NCH/2-1:0] fuse_w,
    input logic             arm_w,
    input logic             lvl_w,
    input logic             force_w
);
    assert_sd_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_w && sd_in == lvl_w) |=> sd_flag_o);

    assert_sd_force_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sd_flag_o |-> (pwm_o == {NCH{force_w}}));

    for (genvar k = 0; k < NCH/2; k++) begin : g_chk
        assert_fused_even_R9: assert property (@(posedge clk) disable iff (!rst_n)
            fuse_w[k] |=> (sd_flag_o || !pwm_o[2*k]));

        assert_idle_odd_R5: assert property (@(posedge clk) disable iff (!rst_n)
            !en_w[2*k+1] |=> (sd_flag_o || pwm_o[2*k+1] == !$past(pol_w[2*k+1])));

        assert_idle_even_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (!en_w[2*k] && !fuse_w[k]) |=> (sd_flag_o || pwm_o[2*k] == !$past(pol_w[2*k])));
    end
endmodule

bind pwm_oct pwm_oct_chk #(.NCH(NCH)) u_chk (
    .clk(clk), .rst_n(rst_n), .sd_in(sd_in), .pwm_o(pwm_o),
    .sd_flag_o(sd_flag_o), .en_w(en_w), .pol_w(pol_w), .fuse_w(fuse_w),
    .arm_w(arm_w), .lvl_w(lvl_w), .force_w(force_w)
);

// File: tb/pwm_oct_tb_top.sv
module pwm_oct_tb_top;
    import pwm_oct_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [4:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       sd_in = 1'b0;
    logic [7:0] pwm_o;
    logic       sd_flag_o;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pwm_oct dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .sd_in(sd_in), .pwm_o(pwm_o), .sd_flag_o(sd_flag_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic measure(input int ch, input int n, output int hi, output int rises);
        logic prev;
        hi = 0; rises = 0;
        prev = pwm_o[ch];
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_o[ch]) hi++;
            if (pwm_o[ch] && !prev) rises++;
            prev = pwm_o[ch];
        end
    endtask

    function automatic int exp_high(int per, int duty, bit ctr, int t, int k, bit pol);
        int act_ticks, win;
        act_ticks = (duty < per) ? duty : per;
        win = k * (ctr ? 2 : 1) * per * t;
        exp_high = k * (ctr ? 2 : 1) * act_ticks * t;
        if (!pol) exp_high = win - exp_high;
    endfunction

    initial begin
        #(1_900_000ns);
        nerr++;
        nchk++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        int hi, rises, cnt;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(pwm_o == 8'h00, "R1 pins", pwm_o, 0);
        chk(sd_flag_o == 1'b0, "R1 flag", sd_flag_o, 0);

        // R5 disabled channel with polarity 0 idles high
        wr(A_POLAR, 8'hFE);
        @(negedge clk);
        chk(pwm_o[0] == 1'b1, "R5 idle pol0", pwm_o[0], 1);
        wr(A_POLAR, 8'hFF);

        // Random trials: R2 R3 R4 R7 R8
        for (int it = 0; it < 24; it++) begin
            int ch, per, duty, pa, sc, t, eff, win, e;
            bit ctr, pol, sel;
            string tag;
            ch   = $urandom % 8;
            per  = 1 + $urandom % 24;
            duty = $urandom % (per + 3);
            ctr  = $urandom % 2;
            pol  = $urandom % 2;
            sel  = $urandom % 2;
            pa   = $urandom % 3;
            sc   = 1 + $urandom % 4;
            wr(A_ENABLE, 8'h00);
            wr(A_PRESC, 8'((pa << 4) | pa));
            wr(A_SCALEA, 8'(sc));
            wr(A_SCALEB, 8'(sc));
            wr(A_CSEL, 8'(sel << ch));
            wr(A_POLAR, 8'(pol << ch));
            wr(A_CENTER, 8'(ctr << ch));
            wr(A_PERIOD + 5'(ch), 8'(per));
            wr(A_DUTY + 5'(ch), 8'(duty));
            wr(A_ENABLE, 8'(1 << ch));
            t   = (1 << pa) * (sel ? sc : 1);
            eff = (ctr ? 2 : 1) * per * t;
            repeat (eff + 2 * t + 2) @(negedge clk);
            win = 2 * eff;
            measure(ch, win, hi, rises);
            e = exp_high(per, duty, ctr, t, 2, pol);
            tag = $sformatf("%s/%s/%s/%s high ch%0d", ctr ? "R3" : "R2",
                            pol ? "R2" : "R4", "R7", sel ? "R8" : "R7", ch);
            chk(hi == e, tag, hi, e);
            if (duty > 0 && duty < per)
                chk(rises == 2, "R2/R3 period count", rises, 2);
        end

        // R8 scale value 0 means 256
        wr(A_ENABLE, 8'h00);
        wr(A_PRESC, 8'h00);
        wr(A_SCALEA, 8'h00);
        wr(A_CSEL, 8'h01);
        wr(A_POLAR, 8'h01);
        wr(A_CENTER, 8'h00);
        wr(A_PERIOD + 5'd0, 8'd2);
        wr(A_DUTY + 5'd0, 8'd1);
        wr(A_ENABLE, 8'h01);
        repeat (600) @(negedge clk);
        measure(0, 1024, hi, rises);
        chk(hi == 512, "R8 scale zero", hi, 512);

        // R5 disabled channel loads shadow at once
        wr(A_ENABLE, 8'h00);
        wr(A_CSEL, 8'h00);
        wr(A_POLAR, 8'hFF);
        wr(A_PERIOD + 5'd5, 8'd10);
        wr(A_DUTY + 5'd5, 8'd4);
        wr(A_ENABLE, 8'h20);
        repeat (25) @(negedge clk);
        wr(A_ENABLE, 8'h00);
        wr(A_PERIOD + 5'd5, 8'd20);
        wr(A_DUTY + 5'd5, 8'd15);
        wr(A_ENABLE, 8'h20);
        measure(5, 20, hi, rises);
        chk(hi == 15, "R5 first period", hi, 15);

        // R6 double buffering on a running channel
        wr(A_ENABLE, 8'h00);
        wr(A_PERIOD + 5'd3, 8'd100);
        wr(A_DUTY + 5'd3, 8'd50);
        wr(A_ENABLE, 8'h08);
        cnt = 0;
        while (!pwm_o[3] && cnt < 300) begin @(negedge clk); cnt++; end
        while (pwm_o[3] && cnt < 300) begin @(negedge clk); cnt++; end
        wr(A_DUTY + 5'd3, 8'd80);
        measure(3, 40, hi, rises);
        chk(hi == 0, "R6 no midperiod change", hi, 0);
        cnt = 0;
        while (!pwm_o[3] && cnt < 300) begin @(negedge clk); cnt++; end
        hi = 0;
        while (pwm_o[3] && cnt < 600) begin @(negedge clk); cnt++; hi++; end
        chk(hi == 80, "R6 next period pulse", hi, 80);

        // R9 fused pair 0: period 0x0120, duty 0x0090
        wr(A_ENABLE, 8'h00);
        wr(A_FUSE, 8'h01);
        wr(A_PERIOD + 5'd0, 8'h01);
        wr(A_PERIOD + 5'd1, 8'h20);
        wr(A_DUTY + 5'd0, 8'h00);
        wr(A_DUTY + 5'd1, 8'h90);
        wr(A_ENABLE, 8'h03);
        repeat (300) @(negedge clk);
        measure(1, 576, hi, rises);
        chk(hi == 288, "R9 fused odd high", hi, 288);
        measure(0, 300, hi, rises);
        chk(hi == 0, "R9 fused even pin", hi, 0);
        wr(A_ENABLE, 8'h00);
        wr(A_FUSE, 8'h00);

        // R10 armed, fault level 1, force 1
        wr(A_SHUT, 8'h07);
        @(negedge clk); sd_in = 1'b1;
        @(negedge clk); sd_in = 1'b0;
        chk(sd_flag_o == 1'b1, "R10 latch set", sd_flag_o, 1);
        chk(pwm_o == 8'hFF, "R10 forced", pwm_o, 8'hFF);
        repeat (5) @(negedge clk);
        chk(sd_flag_o == 1'b1 && pwm_o == 8'hFF, "R10 latch hold", pwm_o, 8'hFF);
        // R11 clear
        wr(A_SHUT, 8'h0F);
        chk(sd_flag_o == 1'b0, "R11 cleared", sd_flag_o, 0);
        @(negedge clk);
        chk(pwm_o == 8'h00, "R11 pins resume", pwm_o, 0);
        // R10 disarmed ignores the input
        wr(A_SHUT, 8'h06);
        @(negedge clk); sd_in = 1'b1;
        repeat (3) @(negedge clk);
        sd_in = 1'b0;
        chk(sd_flag_o == 1'b0, "R10 disarmed flag", sd_flag_o, 0);
        chk(pwm_o == 8'h00, "R10 disarmed pins", pwm_o, 0);
        // R10 fault level 0, forced level 0, idle pins high
        wr(A_POLAR, 8'h00);
        wr(A_SHUT, 8'h01);
        @(negedge clk);
        chk(sd_flag_o == 1'b1, "R10 low level", sd_flag_o, 1);
        chk(pwm_o == 8'h00, "R10 forced low", pwm_o, 0);
        sd_in = 1'b1;
        wr(A_SHUT, 8'h09);
        @(negedge clk);
        chk(sd_flag_o == 1'b0, "R11 clear low", sd_flag_o, 0);
        chk(pwm_o == 8'hFF, "R11 idle after clear", pwm_o, 8'hFF);

        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule